// File: doc/BRIEF.md
# USB Low-Speed Transaction Responder

This block decides how a low-speed USB device function answers each packet the receiver hands it. A packet arrives as its first bytes, its total byte count and a one-cycle end-of-packet strobe. The block checks the packet identifier, the device address and the endpoint. It keeps a note of the token that opened the current transaction. It owns a receive area made of two halves, with a length register, a token register and an offset register that points at the half the next packet fills. It also holds one transmit length/status register for each IN endpoint.

The block answers each packet in one of three ways. It stays silent, it asks for a handshake (ACK, NAK or any code stored by firmware), or it asks for a prepared data packet. A data request names the endpoint whose buffer is to be sent and carries that endpoint's length register value. Firmware reads the receive registers through the host-side ports. It frees the receive area, or marks flow control, by writing the receive length. It arms an IN endpoint by writing its transmit register. NRZI coding, CRC checking and the line drivers sit outside this block.

Top module: `usb_txn_responder`

## Requirements
- R1: After reset there is no reply, the receive length, receive token and receive offset read zero, the current token is zero, and every transmit register holds NAK (0x5A), so an IN is answered with NAK.
- R2: A packet with a total length below 3 bytes produces no reply and changes no state.
- R3: For any PID other than DATA0 (0xC3) and DATA1 (0x4B), the token is addressed to this device only when bits 6:0 of the second byte equal `dev_addr`. A mismatch, or a matching address with a PID other than IN (0x69), SETUP (0x2D) or OUT (0xE1), clears the current token to zero and produces no reply.
- R4: A matching SETUP stores 0x2D as the current token. A matching OUT stores 0xE1, or 0xFF when bit 7 of the second byte is set (OUT to endpoint 1). Neither produces a reply.
- R5: DATA0 and DATA1 packets skip the address check. When the current token is zero they produce no reply and change no state.
- R6: A data packet with a nonzero current token and a nonzero receive length is answered with NAK and is not stored.
- R7: A data packet with a total length below 4, a nonzero current token and a zero receive length is answered with ACK. The receive registers stay unchanged.
- R8: A data packet with a total length of 4 or more, a nonzero current token and a zero receive length is answered with ACK. It stores its total length in the receive length and the current token in the receive token. It moves the receive offset to BUF_BYTES minus the old offset.
- R9: An IN with a signed receive length of 1 or more is answered with NAK. Zero or negative values let the IN proceed.
- R10: A proceeding IN whose selected transmit register has bit 4 set is answered with a handshake carrying that register's value.
- R11: A proceeding IN whose selected transmit register has bit 4 clear gets a data reply with that endpoint number and the register value as its code. The register is reloaded with NAK in the same cycle, and this reload takes priority over a host write in that cycle.
- R12: The endpoint is 0 when bit 7 of the second byte is clear. It is 1 when that bit is set and bit 0 of the third byte is clear. It is 2 when both are set.
- R13: A reply is a one-cycle pulse in the cycle after the end-of-packet strobe. Host writes take effect at the next clock edge, and a host write to endpoint 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_done | input | 1 | End-of-packet strobe, one cycle |
| pkt_len | input | 8 | Total bytes in the packet, PID included |
| pkt_pid | input | 8 | First byte (PID) |
| pkt_addr | input | 8 | Second byte: address in 6:0, endpoint bit in 7 |
| pkt_sel2 | input | 1 | Bit 0 of the third byte |
| dev_addr | input | 7 | Device address |
| host_rx_wr | input | 1 | Write strobe for the receive length |
| host_rx_val | input | 8 | Receive length value to write (signed) |
| host_tx_wr | input | 1 | Write strobe for a transmit register |
| host_tx_ep | input | 2 | Endpoint of the transmit register to write |
| host_tx_val | input | 8 | Length, or a handshake code with bit 4 set |
| reply_valid | output | 1 | Reply request pulse |
| reply_data | output | 1 | 1: send a data buffer, 0: send a handshake |
| reply_ep | output | 2 | Endpoint of the data buffer |
| reply_code | output | 8 | Handshake PID, or the data length register value |
| host_rx_len | output | 8 | Receive length |
| host_rx_tok | output | 8 | Token stored with the received data |
| host_rx_ofs | output | 8 | Offset of the receive half to be filled next |

## Verification
The block holds its state in a few registers, so a wrong value shows up at the ports on the next packet that reads it. A wrong current token turns into a missing ACK, or an ACK that should not be there, on the next data packet. A stale receive length shows up at once on the host read port, and also as a NAK on the next IN or data packet. A transmit register that is not reloaded sends a second data reply where NAK is due. A wrong offset is read directly after every stored packet. The reference model is compared against every output on every clock, so any of these faults is reported in the cycle its effect reaches the ports.

// File: rtl/usbr_pkg.sv
package usbr_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_EP = 3;
  localparam int EP_W   = 2;

  localparam logic [BYTE_W-1:0] PID_OUT   = 8'hE1;
  localparam logic [BYTE_W-1:0] PID_IN    = 8'h69;
  localparam logic [BYTE_W-1:0] PID_SETUP = 8'h2D;
  localparam logic [BYTE_W-1:0] PID_DATA0 = 8'hC3;
  localparam logic [BYTE_W-1:0] PID_DATA1 = 8'h4B;
  localparam logic [BYTE_W-1:0] PID_ACK   = 8'hD2;
  localparam logic [BYTE_W-1:0] PID_NAK   = 8'h5A;
  localparam logic [BYTE_W-1:0] TOK_EP1_OUT = 8'hFF;

  // bit 4 marks a handshake code in a transmit register
  function automatic logic holds_handshake(input logic [BYTE_W-1:0] v);
    return v[4];
  endfunction

  // the other receive half
  function automatic logic [BYTE_W-1:0] other_half(input logic [BYTE_W-1:0] ofs,
                                                   input int unsigned bytes);
    return BYTE_W'(bytes) - ofs;
  endfunction

  function automatic logic [EP_W-1:0] pick_ep(input logic ep_bit, input logic sel2);
    if (!ep_bit) return 2'd0;
    return sel2 ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/usbr_decode.sv
module usbr_decode
  import usbr_pkg::*;
(
  input  logic [BYTE_W-1:0] len,
  input  logic [BYTE_W-1:0] pid,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              sel2,
  input  logic [6:0]        dev_addr,
  output logic              is_data,
  output logic              is_in,
  output logic              is_so,
  output logic              tok_drop,
  output logic [BYTE_W-1:0] so_tok,
  output logic [EP_W-1:0]   ep_sel
);
  logic long_enough, data_pid, addr_ok, known_tok;

  always_comb begin
    long_enough = (len >= 8'd3);
    data_pid    = (pid == PID_DATA0) || (pid == PID_DATA1);
    addr_ok     = (addr_byte[6:0] == dev_addr);
    known_tok   = (pid == PID_IN) || (pid == PID_SETUP) || (pid == PID_OUT);
    is_data     = long_enough && data_pid;
    is_in       = long_enough && !data_pid && addr_ok && (pid == PID_IN);
    is_so       = long_enough && !data_pid && addr_ok && (pid != PID_IN) && known_tok;
    tok_drop    = long_enough && !data_pid && !(addr_ok && known_tok);
    so_tok      = ((pid == PID_OUT) && addr_byte[7]) ? TOK_EP1_OUT : pid;
    ep_sel      = pick_ep(addr_byte[7], sel2);
  end
endmodule

// File: rtl/usbr_rx_state.sv
module usbr_rx_state
  import usbr_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_done,
  input  logic [BYTE_W-1:0] len,
  input  logic              is_data,
  input  logic              is_so,
  input  logic              tok_drop,
  input  logic [BYTE_W-1:0] so_tok,
  input  logic              host_rx_wr,
  input  logic [BYTE_W-1:0] host_rx_val,
  output logic [BYTE_W-1:0] cur_tok,
  output logic [BYTE_W-1:0] rx_len,
  output logic [BYTE_W-1:0] rx_tok,
  output logic [BYTE_W-1:0] rx_ofs,
  output logic              data_nak,
  output logic              data_ack,
  output logic              data_store,
  output logic              in_busy
);
  logic data_live;

  always_comb begin
    data_live  = pkt_done && is_data && (cur_tok != '0);
    data_nak   = data_live && (rx_len != '0);
    data_ack   = data_live && (rx_len == '0);
    data_store = data_ack && (len >= 8'd4);
    in_busy    = ($signed(rx_len) > 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_tok <= '0;
      rx_len  <= '0;
      rx_tok  <= '0;
      rx_ofs  <= '0;
    end else begin
      if (pkt_done && tok_drop) cur_tok <= '0;
      else if (pkt_done && is_so) cur_tok <= so_tok;
      if (data_store) begin
        rx_len <= len;
        rx_tok <= cur_tok;
        rx_ofs <= other_half(rx_ofs, BUF_BYTES);
      end else if (host_rx_wr) begin
        rx_len <= host_rx_val;
      end
    end
  end
endmodule

// File: rtl/usbr_tx_regs.sv
module usbr_tx_regs
  import usbr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_tx_wr,
  input  logic [EP_W-1:0]          host_tx_ep,
  input  logic [BYTE_W-1:0]        host_tx_val,
  input  logic                     load_nak,
  input  logic [EP_W-1:0]          nak_ep,
  output logic [NUM_EP*BYTE_W-1:0] tx_flat
);
  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic [BYTE_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= PID_NAK;
      else if (load_nak && (nak_ep == EP_W'(e))) val_q <= PID_NAK;
      else if (host_tx_wr && (host_tx_ep == EP_W'(e))) val_q <= host_tx_val;
    end
    assign tx_flat[e*BYTE_W +: BYTE_W] = val_q;
  end
endmodule

// File: rtl/usb_txn_responder.sv
module usb_txn_responder
  import usbr_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_done,
  input  logic [7:0] pkt_len,
  input  logic [7:0] pkt_pid,
  input  logic [7:0] pkt_addr,
  input  logic       pkt_sel2,
  input  logic [6:0] dev_addr,
  input  logic       host_rx_wr,
  input  logic [7:0] host_rx_val,
  input  logic       host_tx_wr,
  input  logic [1:0] host_tx_ep,
  input  logic [7:0] host_tx_val,
  output logic       reply_valid,
  output logic       reply_data,
  output logic [1:0] reply_ep,
  output logic [7:0] reply_code,
  output logic [7:0] host_rx_len,
  output logic [7:0] host_rx_tok,
  output logic [7:0] host_rx_ofs
);
  logic              is_data, is_in, is_so, tok_drop;
  logic [BYTE_W-1:0] so_tok, cur_tok;
  logic [EP_W-1:0]   ep_sel;
  logic              data_nak, data_ack, data_store, in_busy;
  logic [NUM_EP*BYTE_W-1:0] tx_flat;
  logic [BYTE_W-1:0] tx_sel;
  logic              in_nak, take_in, send_hs, send_data;

  usbr_decode u_dec (
    .len(pkt_len), .pid(pkt_pid), .addr_byte(pkt_addr), .sel2(pkt_sel2),
    .dev_addr(dev_addr), .is_data(is_data), .is_in(is_in), .is_so(is_so),
    .tok_drop(tok_drop), .so_tok(so_tok), .ep_sel(ep_sel)
  );

  usbr_rx_state #(.BUF_BYTES(BUF_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .len(pkt_len),
    .is_data(is_data), .is_so(is_so), .tok_drop(tok_drop), .so_tok(so_tok),
    .host_rx_wr(host_rx_wr), .host_rx_val(host_rx_val), .cur_tok(cur_tok),
    .rx_len(host_rx_len), .rx_tok(host_rx_tok), .rx_ofs(host_rx_ofs),
    .data_nak(data_nak), .data_ack(data_ack), .data_store(data_store),
    .in_busy(in_busy)
  );

  usbr_tx_regs u_tx (
    .clk(clk), .rst_n(rst_n), .host_tx_wr(host_tx_wr), .host_tx_ep(host_tx_ep),
    .host_tx_val(host_tx_val), .load_nak(send_data), .nak_ep(ep_sel),
    .tx_flat(tx_flat)
  );

  always_comb begin
    tx_sel    = tx_flat[int'(ep_sel)*BYTE_W +: BYTE_W];
    in_nak    = pkt_done && is_in && in_busy;
    take_in   = pkt_done && is_in && !in_busy;
    send_hs   = take_in && holds_handshake(tx_sel);
    send_data = take_in && !holds_handshake(tx_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_valid <= 1'b0;
      reply_data  <= 1'b0;
      reply_ep    <= '0;
      reply_code  <= '0;
    end else begin
      reply_valid <= data_nak || data_ack || in_nak || take_in;
      reply_data  <= send_data;
      reply_ep    <= send_data ? ep_sel : '0;
      if (data_nak || in_nak)         reply_code <= PID_NAK;
      else if (data_ack)              reply_code <= PID_ACK;
      else if (send_hs || send_data)  reply_code <= tx_sel;
      else                            reply_code <= '0;
    end
  end
endmodule

// File: rtl/usbr_checker.sv
module usbr_checker
  import usbr_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pkt_done,
  input logic [7:0]               pkt_len,
  input logic                     host_rx_wr,
  input logic                     reply_valid,
  input logic                     reply_data,
  input logic [1:0]               reply_ep,
  input logic [7:0]               reply_code,
  input logic [7:0]               rx_len,
  input logic [7:0]               rx_ofs,
  input logic [NUM_EP*BYTE_W-1:0] tx_flat
);
  p_reply_after_pkt_r13: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> $past(pkt_done));

  p_short_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && pkt_len < 8'd3) |=> !reply_valid);

  p_hs_bit4_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && !reply_data) |-> reply_code[4]);

  p_data_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_data) |-> (!reply_code[4] &&
      tx_flat[int'(reply_ep)*BYTE_W +: BYTE_W] == PID_NAK));

  p_ep_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_data) |-> (int'(reply_ep) < NUM_EP));

  p_ofs_halves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ofs == 8'd0) || (rx_ofs == 8'(BUF_BYTES)));

  p_rxlen_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_len) |-> $past(pkt_done || host_rx_wr));
endmodule

bind usb_txn_responder usbr_checker #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_len(pkt_len),
  .host_rx_wr(host_rx_wr), .reply_valid(reply_valid), .reply_data(reply_data),
  .reply_ep(reply_ep), .reply_code(reply_code), .rx_len(host_rx_len),
  .rx_ofs(host_rx_ofs), .tx_flat(tx_flat)
);

// File: tb/test_usb_txn_responder.sv
module test_usb_txn_responder;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 11;
  localparam logic [6:0] ADDR = 7'h05;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_done = 0, pkt_sel2 = 0, host_rx_wr = 0, host_tx_wr = 0;
  logic [7:0] pkt_len = 0, pkt_pid = 0, pkt_addr = 0, host_rx_val = 0, host_tx_val = 0;
  logic [1:0] host_tx_ep = 0;
  logic reply_valid, reply_data;
  logic [1:0] reply_ep;
  logic [7:0] reply_code, host_rx_len, host_rx_tok, host_rx_ofs;

  int checks = 0, fails = 0;

  // reference model state
  int m_tok = 0, m_rxlen = 0, m_rxtok = 0, m_ofs = 0;
  int m_tx[3] = '{8'h5A, 8'h5A, 8'h5A};
  int m_rv = 0, m_rd = 0, m_rep = 0, m_rc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_txn_responder #(.BUF_BYTES(BUF)) i_usb_txn_responder (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .pkt_pid(pkt_pid), .pkt_addr(pkt_addr), .pkt_sel2(pkt_sel2), .dev_addr(ADDR),
    .host_rx_wr(host_rx_wr), .host_rx_val(host_rx_val), .host_tx_wr(host_tx_wr),
    .host_tx_ep(host_tx_ep), .host_tx_val(host_tx_val), .reply_valid(reply_valid),
    .reply_data(reply_data), .reply_ep(reply_ep), .reply_code(reply_code),
    .host_rx_len(host_rx_len), .host_rx_tok(host_rx_tok), .host_rx_ofs(host_rx_ofs)
  );

  function automatic int as_signed8(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic model_step();
    int ep;
    m_rv = 0; m_rd = 0; m_rep = 0; m_rc = 0;
    if (host_rx_wr) m_rxlen = host_rx_val;
    if (host_tx_wr && host_tx_ep != 2'd3) m_tx[host_tx_ep] = host_tx_val;
    if (!pkt_done || pkt_len < 3) return;
    if (pkt_pid == 8'hC3 || pkt_pid == 8'h4B) begin
      if (m_tok == 0) return;
      m_rv = 1;
      if (m_rxlen != 0) m_rc = 8'h5A;
      else begin
        m_rc = 8'hD2;
        if (pkt_len >= 4) begin
          m_rxlen = pkt_len; m_rxtok = m_tok; m_ofs = BUF - m_ofs;
        end
      end
      return;
    end
    if (pkt_addr[6:0] != ADDR) begin m_tok = 0; return; end
    case (pkt_pid)
      8'h69: begin
        ep = !pkt_addr[7] ? 0 : (pkt_sel2 ? 2 : 1);
        m_rv = 1;
        if (as_signed8(m_rxlen) >= 1) m_rc = 8'h5A;
        else if ((m_tx[ep] & 16) != 0) m_rc = m_tx[ep];
        else begin m_rd = 1; m_rep = ep; m_rc = m_tx[ep]; m_tx[ep] = 8'h5A; end
      end
      8'h2D: m_tok = 8'h2D;
      8'hE1: m_tok = pkt_addr[7] ? 8'hFF : 8'hE1;
      default: m_tok = 0;
    endcase
  endtask

  task automatic compare(input string tag);
    checks++;
    if (reply_valid !== m_rv[0] || reply_data !== m_rd[0] || reply_ep !== m_rep[1:0] ||
        reply_code !== m_rc[7:0] || host_rx_len !== m_rxlen[7:0] ||
        host_rx_tok !== m_rxtok[7:0] || host_rx_ofs !== m_ofs[7:0]) begin
      fails++;
      $display("FAIL %s actual v=%0b d=%0b ep=%0d code=%h len=%h tok=%h ofs=%0d expected v=%0d d=%0d ep=%0d code=%h len=%h tok=%h ofs=%0d",
               tag, reply_valid, reply_data, reply_ep, reply_code, host_rx_len, host_rx_tok,
               host_rx_ofs, m_rv, m_rd, m_rep, m_rc[7:0], m_rxlen[7:0], m_rxtok[7:0], m_ofs);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    pkt_done = 0; host_rx_wr = 0; host_tx_wr = 0;
  endtask

  task automatic pkt(input string tag, input int len, input logic [7:0] pid,
                     input logic [7:0] ab, input logic s2);
    pkt_done = 1; pkt_len = 8'(len); pkt_pid = pid; pkt_addr = ab; pkt_sel2 = s2;
    tick(tag);
    tick(tag); // reply pulse must drop (R13)
  endtask

  task automatic rxw(input string tag, input logic [7:0] v);
    host_rx_wr = 1; host_rx_val = v; tick(tag);
  endtask

  task automatic txw(input string tag, input logic [1:0] ep, input logic [7:0] v);
    host_tx_wr = 1; host_tx_ep = ep; host_tx_val = v; tick(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset");
    pkt("R1 in after reset", 3, 8'h69, 8'h05, 0);
    pkt("R2 short", 2, 8'h2D, 8'h05, 0);
    pkt("R5 data no token", 5, 8'hC3, 8'h05, 0);
    pkt("R4 setup", 3, 8'h2D, 8'h05, 0);
    pkt("R8 store", 11, 8'hC3, 8'h7F, 0);
    pkt("R6 busy data", 6, 8'h4B, 8'h05, 0);
    pkt("R9 in busy", 3, 8'h69, 8'h05, 0);
    rxw("R13 free", 8'h00);
    txw("R11 arm ep0", 2'd0, 8'h08);
    pkt("R11 data reply ep0", 3, 8'h69, 8'h05, 0);
    pkt("R11 reloaded", 3, 8'h69, 8'h05, 0);
    rxw("R9 flow", 8'hFF);
    txw("R10 stall ep1", 2'd1, 8'h1E);
    pkt("R10 hs ep1", 3, 8'h69, 8'h85, 0);
    txw("R12 arm ep2", 2'd2, 8'h03);
    pkt("R12 ep2", 3, 8'h69, 8'h85, 1);
    pkt("R12 ep2 again", 3, 8'h69, 8'h85, 1);
    txw("R13 ep3 ignored", 2'd3, 8'h04);
    pkt("R12 ep0 still nak", 3, 8'h69, 8'h05, 1);
    rxw("R13 free", 8'h00);
    pkt("R4 out ep1", 3, 8'hE1, 8'h85, 0);
    pkt("R7 status", 3, 8'hC3, 8'h00, 0);
    pkt("R8 store ep1 out", 5, 8'h4B, 8'h00, 0);
    rxw("R13 free", 8'h00);
    pkt("R4 out ep0", 3, 8'hE1, 8'h05, 0);
    pkt("R7 status zero", 3, 8'h4B, 8'h05, 0);
    pkt("R3 addr miss", 3, 8'h2D, 8'h06, 0);
    pkt("R3 cleared", 5, 8'hC3, 8'h05, 0);
    pkt("R4 setup", 3, 8'h2D, 8'h05, 0);
    pkt("R3 unknown pid", 3, 8'hD2, 8'h05, 0);
    pkt("R3 cleared2", 5, 8'hC3, 8'h05, 0);
    pkt("R4 setup", 3, 8'h2D, 8'h05, 0);
    pkt("R2 short data", 1, 8'hC3, 8'h05, 0);
    pkt("R5 data any addr", 4, 8'hC3, 8'h33, 0);
    txw("R11 arm ep1", 2'd1, 8'h02);
    rxw("R9 free", 8'h00);
    pkt("R11 data ep1", 3, 8'h69, 8'h85, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule